// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. A 32-bit down-counter runs while the watchdog is enabled. If it reaches zero, the block raises a reset request that stays high until the block itself is reset. Software keeps the watchdog alive by writing a fixed pair of key words, in order, to the service register. Each completed pair reloads the counter from the timeout register. The control register has two pause options. One halts counting while a debug-halt input is high. The other halts counting while a low-power-stop input is high.

The register bus is minimal. It has a byte address, a write strobe and write data, and the read data is decoded combinationally from the address. A new timeout value is not used straight away. The counter picks it up only when a key pair completes or when the watchdog goes from disabled to enabled. When it is picked up, any value below 0x100 is raised to 0x100. The live count can be read only while the watchdog is disabled. While it is enabled, the counter register keeps showing the last value captured while it was disabled.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, control reads 0, timeout reads 0x000FFFFF, the counter register reads 0 and the reset request is low. The block decodes four byte offsets: control at 0x00, timeout at 0x08, service at 0x10 and counter at 0x14. The service register and every unmapped offset read 0. Writes to unmapped offsets and to the counter offset change nothing.
- R2: The control register has these fields: bit 0 enable, bit 1 debug freeze, bit 2 low-power stop, and bits 10:9 service mode. All other bits read back 0.
- R3: A control write that changes enable from 0 to 1 loads the counter with the timeout value on the same clock edge. A value below 0x100 is loaded as 0x100. The largest value, 0xFFFFFFFF, is loaded unchanged.
- R4: A timeout write does not change a count that is already running. The timeout register reads back the raw value that was written.
- R5: The refresh works only when service mode is 00. Software writes 0x0000A602 to the service register and then writes 0x0000B480 as the next service write. The counter reloads from the timeout value, clamped as in R3, on the edge of the second write.
- R6: Three kinds of service write send the key state back to idle without a reload. These are 0x0000B480 written without a preceding 0x0000A602, a repeated 0x0000A602, and any other value.
- R7: While enabled, the counter drops by one each clock. It holds while the count is 0, while disabled, while the freeze bit and debug-halt input are both high, or while the stop bit and low-power-stop input are both high.
- R8: While enable is 0, the counter register reads the live count. While enable is 1, it reads the count captured in the last cycle before enabling.
- R9: The reset request rises one clock after a cycle in which the watchdog is enabled and the count is 0. Once high, it stays high until reset, even if the watchdog is disabled.
- R10: Suppose the second key write lands in the cycle in which an enabled count is 0. The reload wins and no reset request is raised. A refresh one cycle later does not clear a request that is already high.
- R11: While the service mode is not 00, key writes do not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| dbg_halt | input | 1 | Debug halt status |
| lp_stop | input | 1 | Low-power stop status |
| rst_req | output | 1 | Sticky reset request on expiry |

## Verification
Two functions can fall in the same cycle: expiry and the refresh reload. The bench counts clock edges from the enable write and places the second key write on exactly the edge where the enabled count is zero. The expected result is that the reload wins, the request stays low and the counter restarts from the clamped timeout. A second run places the key write one edge later and expects the request to be already high and to stay high.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned BUS_W = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_TMO  = 8'h08;
    localparam logic [7:0] OFS_SVC  = 8'h10;
    localparam logic [7:0] OFS_CNT  = 8'h14;

    localparam int unsigned BIT_EN      = 0;
    localparam int unsigned BIT_FRZ     = 1;
    localparam int unsigned BIT_STP     = 2;
    localparam int unsigned BIT_MODE_LO = 9;
    localparam int unsigned BIT_MODE_HI = 10;

    localparam logic [1:0] MODE_FIXED = 2'b00;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 32'h0000_A602;
    localparam logic [BUS_W-1:0] KEY_SECOND = 32'h0000_B480;

    typedef struct packed {
        logic       en;
        logic       frz;
        logic       stp;
        logic [1:0] mode;
    } ctrl_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 32,
    parameter logic [CNT_W-1:0] TMO_RESET = 32'h000F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic [CNT_W-1:0]  cnt_snap,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  tmo,
    output logic              en_rise,
    output logic              svc_we,
    output logic [BUS_W-1:0]  rdata
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] tmo;
    } regs_t;

    regs_t st_d, st_q;

    logic hit_ctrl, hit_tmo, hit_svc, hit_cnt;

    always_comb begin
        hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit_tmo  = (addr == ADDR_W'(OFS_TMO));
        hit_svc  = (addr == ADDR_W'(OFS_SVC));
        hit_cnt  = (addr == ADDR_W'(OFS_CNT));

        st_d = st_q;
        if (we && hit_ctrl) begin
            st_d.ctrl.en   = wdata[BIT_EN];
            st_d.ctrl.frz  = wdata[BIT_FRZ];
            st_d.ctrl.stp  = wdata[BIT_STP];
            st_d.ctrl.mode = wdata[BIT_MODE_HI:BIT_MODE_LO];
        end
        if (we && hit_tmo) begin
            st_d.tmo = wdata[CNT_W-1:0];
        end

        en_rise = we && hit_ctrl && wdata[BIT_EN] && !st_q.ctrl.en;
        svc_we  = we && hit_svc;

        rdata = '0;
        if (hit_ctrl) begin
            rdata[BIT_EN]                  = st_q.ctrl.en;
            rdata[BIT_FRZ]                 = st_q.ctrl.frz;
            rdata[BIT_STP]                 = st_q.ctrl.stp;
            rdata[BIT_MODE_HI:BIT_MODE_LO] = st_q.ctrl.mode;
        end else if (hit_tmo) begin
            rdata = BUS_W'(st_q.tmo);
        end else if (hit_cnt) begin
            rdata = st_q.ctrl.en ? BUS_W'(cnt_snap) : BUS_W'(cnt_live);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.tmo  <= TMO_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
    assign tmo  = st_q.tmo;

endmodule

// File: rtl/kwdt_seq.sv
module kwdt_seq
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic [1:0]       mode,
    output logic             refresh
);

    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        refresh = 1'b0;
        if (svc_we) begin
            st_d.state = SEQ_IDLE;
            if (mode == MODE_FIXED) begin
                unique case (st_q.state)
                    SEQ_IDLE: begin
                        if (wdata == KEY_FIRST) st_d.state = SEQ_ARMED;
                    end
                    SEQ_ARMED: begin
                        if (wdata == KEY_SECOND) refresh = 1'b1;
                    end
                    default: st_d.state = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.state <= SEQ_IDLE;
        else        st_q       <= st_d;
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned MIN_LOAD = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] tmo,
    input  logic             load,
    input  logic             dbg_halt,
    input  logic             lp_stop,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             req;
    } cnt_t;

    cnt_t st_d, st_q;

    logic [CNT_W-1:0] load_val;
    logic             paused;
    logic             at_zero;

    always_comb begin
        load_val = (tmo < FLOOR) ? FLOOR : tmo;
        paused   = (ctrl.frz && dbg_halt) || (ctrl.stp && lp_stop);
        at_zero  = (st_q.cnt == '0);

        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (ctrl.en && !paused && !at_zero) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        if (ctrl.en && at_zero && !load) begin
            st_d.req = 1'b1;
        end

        if (!ctrl.en) begin
            st_d.snap = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign snap    = st_q.snap;
    assign rst_req = st_q.req;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned MIN_LOAD  = 256,
    parameter logic [CNT_W-1:0] TMO_RESET = 32'h000F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dbg_halt,
    input  logic              lp_stop,
    output logic              rst_req
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] tmo;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] snap;
    logic             en_rise;
    logic             svc_we;
    logic             refresh;
    logic             load;

    kwdt_regs #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .TMO_RESET (TMO_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .cnt_live (cnt),
        .cnt_snap (snap),
        .ctrl     (ctrl),
        .tmo      (tmo),
        .en_rise  (en_rise),
        .svc_we   (svc_we),
        .rdata    (bus_rdata)
    );

    kwdt_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_we  (svc_we),
        .wdata   (bus_wdata),
        .mode    (ctrl.mode),
        .refresh (refresh)
    );

    assign load = en_rise || refresh;

    kwdt_counter #(
        .CNT_W    (CNT_W),
        .MIN_LOAD (MIN_LOAD)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .tmo      (tmo),
        .load     (load),
        .dbg_halt (dbg_halt),
        .lp_stop  (lp_stop),
        .cnt      (cnt),
        .snap     (snap),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned MIN_LOAD = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             frz,
    input logic             stp,
    input logic [1:0]       mode,
    input logic             dbg_halt,
    input logic             lp_stop,
    input logic             load,
    input logic             refresh,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] snap,
    input logic             rst_req
);

    logic pause;
    assign pause = (frz && dbg_halt) || (stp && lp_stop);

    p_load_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt >= CNT_W'(MIN_LOAD)));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !pause && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (!en || pause)) |=> $stable(cnt));

    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(snap));

    p_sticky_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    p_rise_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(en && cnt == '0 && !load));

    p_refresh_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !rst_req) |=> !rst_req);

    p_mode_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> !refresh);

endmodule

bind keyed_wdt keyed_wdt_chk #(
    .CNT_W    (CNT_W),
    .MIN_LOAD (MIN_LOAD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl.en),
    .frz      (ctrl.frz),
    .stp      (ctrl.stp),
    .mode     (ctrl.mode),
    .dbg_halt (dbg_halt),
    .lp_stop  (lp_stop),
    .load     (load),
    .refresh  (refresh),
    .cnt      (cnt),
    .snap     (snap),
    .rst_req  (rst_req)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_TMO  = 8'h08;
    localparam logic [7:0] A_SVC  = 8'h10;
    localparam logic [7:0] A_CNT  = 8'h14;
    localparam logic [31:0] K1 = 32'h0000_A602;
    localparam logic [31:0] K2 = 32'h0000_B480;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        dbg_halt;
    logic        lp_stop;
    logic        rst_req;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_wr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .dbg_halt  (dbg_halt),
        .lp_stop   (lp_stop),
        .rst_req   (rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        last_wr = cyc;
    endtask

    task automatic wr_at(input logic [7:0] a, input logic [31:0] d, input int edge_no);
        @(negedge clk);
        while (cyc < edge_no - 1) @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 v = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        dbg_halt = 1'b0; lp_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] clampv(input logic [31:0] t);
        return (t < 32'h100) ? 32'h100 : t;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] sweep [7];
        int c0, c1, c2, c3, cr;

        // R1 reset state and decode
        do_reset();
        rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
        rd(A_TMO, v);  check("R1 tmo reset", v, 32'h000F_FFFF);
        rd(A_CNT, v);  check("R1 cnt reset", v, 32'h0);
        rd(A_SVC, v);  check("R1 svc reads 0", v, 32'h0);
        check("R1 req reset", {31'b0, rst_req}, 32'h0);
        for (int a = 0; a < 32; a += 4) begin
            if (a != 0 && a != 8 && a != 16 && a != 20) begin
                wr(8'(a), 32'hFFFF_FFFF);
                rd(8'(a), v); check("R1 unmapped read", v, 32'h0);
            end
        end
        wr(A_CNT, 32'h1234_5678);
        rd(A_CTRL, v); check("R1 ctrl after ignored writes", v, 32'h0);
        rd(A_TMO, v);  check("R1 tmo after ignored writes", v, 32'h000F_FFFF);
        rd(A_CNT, v);  check("R1 cnt after ignored write", v, 32'h0);

        // R2 control field layout
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, v); check("R2 ctrl mask", v, 32'h0000_0600);
        wr(A_CTRL, 32'h0000_0006);
        rd(A_CTRL, v); check("R2 ctrl pause bits", v, 32'h0000_0006);

        // R3 load on enable, clamp sweep
        sweep = '{32'h0, 32'h1, 32'hFF, 32'h100, 32'h101, 32'h1234, 32'hFFFF_FFFF};
        foreach (sweep[i]) begin
            do_reset();
            wr(A_TMO, sweep[i]);
            wr(A_CTRL, 32'h1); c0 = last_wr;
            repeat (5) @(negedge clk);
            wr(A_CTRL, 32'h0); c1 = last_wr;
            rd(A_CNT, v);
            check($sformatf("R3 clamp load %h", sweep[i]), v, clampv(sweep[i]) - 32'(c1 - c0));
            rd(A_TMO, v); check("R4 tmo raw readback", v, sweep[i]);
        end

        // R4 timeout write during run; R3 new value on next enable; R8 snapshot
        do_reset();
        wr(A_TMO, 32'h200);
        wr(A_CTRL, 32'h1); c0 = last_wr;
        wr(A_TMO, 32'h400);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 32'h0); c1 = last_wr;
        rd(A_CNT, v); check("R4 running count kept", v, 32'h200 - 32'(c1 - c0));
        rd(A_TMO, v); check("R4 tmo readback", v, 32'h400);
        wr(A_CTRL, 32'h1); c2 = last_wr;
        rd(A_CNT, v); check("R8 snapshot after enable", v, 32'h200 - 32'(c1 - c0));
        repeat (10) @(negedge clk);
        rd(A_CNT, v); check("R8 snapshot held", v, 32'h200 - 32'(c1 - c0));
        wr(A_CTRL, 32'h0); c3 = last_wr;
        rd(A_CNT, v); check("R3 reload with new tmo", v, 32'h400 - 32'(c3 - c2));
        repeat (4) @(negedge clk);
        rd(A_CNT, v); check("R8 live count while disabled", v, 32'h400 - 32'(c3 - c2));

        // R5 valid refresh
        do_reset();
        wr(A_TMO, 32'h300);
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        wr(A_SVC, K1);
        wr(A_SVC, K2); cr = last_wr;
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h0); c1 = last_wr;
        rd(A_CNT, v); check("R5 refresh reload", v, 32'h300 - 32'(c1 - cr));

        // R6 bad sequences
        for (int p = 0; p < 4; p++) begin
            do_reset();
            wr(A_TMO, 32'h300);
            wr(A_CTRL, 32'h1); c0 = last_wr;
            repeat (10) @(negedge clk);
            case (p)
                0: wr(A_SVC, K2);
                1: begin wr(A_SVC, K1); wr(A_SVC, K1); wr(A_SVC, K2); end
                2: begin wr(A_SVC, K1); wr(A_SVC, 32'h1234); wr(A_SVC, K2); end
                default: begin wr(A_SVC, K1); wr(A_SVC, 32'h0001_B480); wr(A_SVC, K2); end
            endcase
            wr(A_CTRL, 32'h0); c1 = last_wr;
            rd(A_CNT, v);
            check($sformatf("R6 bad sequence %0d", p), v, 32'h300 - 32'(c1 - c0));
        end

        // R7 pause controls
        do_reset();
        wr(A_TMO, 32'h300);
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'h3);
        repeat (15) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R7 debug freeze holds", v, 32'h300);
        wr(A_CTRL, 32'h1); c0 = last_wr;
        repeat (7) @(negedge clk);
        wr(A_CTRL, 32'h0); c1 = last_wr;
        rd(A_CNT, v); check("R7 debug without freeze bit counts", v, 32'h300 - 32'(c1 - c0));
        dbg_halt = 1'b0;
        do_reset();
        wr(A_TMO, 32'h300);
        lp_stop = 1'b1;
        wr(A_CTRL, 32'h5);
        repeat (15) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R7 low-power stop holds", v, 32'h300);
        lp_stop = 1'b0;
        wr(A_CTRL, 32'h5); c0 = last_wr;
        repeat (9) @(negedge clk);
        wr(A_CTRL, 32'h0); c1 = last_wr;
        rd(A_CNT, v); check("R7 stop bit, input low counts", v, 32'h300 - 32'(c1 - c0));

        // R9 expiry timing and stickiness
        do_reset();
        wr(A_TMO, 32'h10);
        wr(A_CTRL, 32'h1); c0 = last_wr;
        while (cyc < c0 + 256) @(negedge clk);
        check("R9 no request at zero edge", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        check("R9 request one edge after zero", {31'b0, rst_req}, 32'h1);
        wr(A_CTRL, 32'h0);
        repeat (10) @(negedge clk);
        check("R9 request sticky after disable", {31'b0, rst_req}, 32'h1);
        rd(A_CNT, v); check("R9 count rests at zero", v, 32'h0);
        do_reset();
        check("R9 request cleared by reset", {31'b0, rst_req}, 32'h0);

        // R10 refresh and expiry in the same cycle
        wr(A_TMO, 32'h100);
        wr(A_CTRL, 32'h1); c0 = last_wr;
        wr(A_SVC, K1);
        wr_at(A_SVC, K2, c0 + 257); cr = last_wr;
        check("R10 refresh edge on zero", cr, c0 + 257);
        check("R10 no request when reload wins", {31'b0, rst_req}, 32'h0);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h0); c1 = last_wr;
        check("R10 still no request", {31'b0, rst_req}, 32'h0);
        rd(A_CNT, v); check("R10 reload value", v, 32'h100 - 32'(c1 - cr));
        do_reset();
        wr(A_TMO, 32'h100);
        wr(A_CTRL, 32'h1); c0 = last_wr;
        wr(A_SVC, K1);
        wr_at(A_SVC, K2, c0 + 258);
        check("R10 late refresh keeps request", {31'b0, rst_req}, 32'h1);

        // R11 non-fixed service mode ignores keys
        do_reset();
        wr(A_TMO, 32'h300);
        wr(A_CTRL, 32'h201); c0 = last_wr;
        repeat (10) @(negedge clk);
        wr(A_SVC, K1);
        wr(A_SVC, K2);
        wr(A_CTRL, 32'h200); c1 = last_wr;
        rd(A_CNT, v); check("R11 keys ignored in other mode", v, 32'h300 - 32'(c1 - c0));
        rd(A_CTRL, v); check("R11 mode readback", v, 32'h200);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule